// File: doc/BRIEF.md
# Clock Source Switching Controller

This block decides which oscillator drives the system clock. There are three choices: the internal RC oscillator, the external crystal oscillator, or a PLL whose reference is either of the two. Software-style configuration arrives over a single request channel. Each request carries a target source, the PLL reference choice and the PLL factors M, N and P. The controller then runs a checked sequence:

1. Enable the oscillators the target needs.
2. Wait for the external ready flag.
3. Start the PLL and wait out its lock time.
4. Move the flash wait-state value and switch the source, in the order that keeps the flash access time safe.

Oscillators and PLL lock are modelled. The external oscillator is a ready input plus a raw clock input. PLL lock is a programmable cycle count that only completes when the computed VCO frequency is legal.

The request channel uses valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While a sequence runs, `req_ready` stays low and the requester must hold `req_valid` and the request fields steady until the transfer. `req_ready` is also low in a cycle where a wake event or an oscillator failure forces the internal source.

A monitor counts internal clock cycles between edges of the external oscillator. If the gap grows too long, the controller falls back to the internal source and raises a sticky failure flag. A wake from stop mode forces the same fallback without the flag.

Top module: `clk_switch_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `clk_sel` is 0 (internal), `ext_en`, `pll_en` and `css_fail` are 0, `flash_ws` is 0, and `req_ready` is 1.
- R2: Source codes are 0 internal, 1 external, 2 PLL and 3 reserved. A request transfers only when `req_valid` and `req_ready` are high together, and `req_ready` stays low from the transfer until the sequence ends. A request with code 3 transfers and changes nothing.
- R3: With P code p (0..3), the PLL values are VCO = f_ref*N/M MHz (integer division) and f_sys = VCO/(2*(p+1)). The reference f_ref is 8 MHz for the external oscillator (`req_pll_ext`=1) and 16 MHz for the internal one. The target wait-state value is (f-1)/30, where f is 16 for the internal source, 8 for the external source and f_sys for the PLL.
- R4: If M is 0 or the VCO lies outside 100..432 MHz, the PLL never locks. After WAIT_LIMIT cycles of waiting, the sequence is abandoned, the PLL is turned off again and `clk_sel` keeps its value.
- R5: `clk_sel` moves to 2 only after `pll_en` has been high for at least `lock_cycles` cycles with a legal VCO.
- R6: When the PLL reference is external, `pll_en` rises only after `ext_rdy` has been seen. If `ext_rdy` never comes, the sequence is abandoned after WAIT_LIMIT cycles and `ext_en` returns to what the active source needs.
- R7: When the target wait-state value is higher, `flash_ws` changes one cycle before the source switch. When it is lower, `flash_ws` changes one cycle after. `flash_ws` and `clk_sel` never change on the same edge.
- R8: `clk_sel` reports the source code currently driving the system clock.
- R9: A request naming the PLL while the PLL is the active source transfers and changes nothing.
- R10: A one-cycle `stop_wake` pulse forces `clk_sel` to 0 and clears `ext_en` and `pll_en` on the next edge, abandoning any sequence. `flash_ws` is kept.
- R11: While the active source uses the external oscillator, a run of more than CSS_WINDOW internal cycles without an external clock edge forces the internal source and turns off both oscillators. It also sets `css_fail`, which stays set until reset.
- R12: At the switch, `ext_en` and `pll_en` keep only the oscillators the new source needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, from the internal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_src | input | 2 | Target source code |
| req_pll_ext | input | 1 | PLL reference: 1 external, 0 internal |
| req_m | input | 6 | PLL input divider M |
| req_n | input | 9 | PLL feedback multiplier N |
| req_p | input | 2 | PLL output divider code, divide by 2*(p+1) |
| lock_cycles | input | 16 | Cycles the PLL needs before it reports lock |
| ext_rdy | input | 1 | External oscillator stable |
| ext_clk | input | 1 | Raw external oscillator, watched by the monitor |
| stop_wake | input | 1 | Wake from stop mode event |
| ext_en | output | 1 | External oscillator enable |
| pll_en | output | 1 | PLL enable |
| flash_ws | output | 4 | Flash wait states |
| clk_sel | output | 2 | Source code actually driving the system clock |
| css_fail | output | 1 | Sticky external oscillator failure flag |

## Verification
The bench targets these corner cases:

- **Queued request.** A second request is queued behind a running PLL sequence. A controller that dropped the back-pressure would lose it or switch mid-lock.
- **Zero lock count and illegal VCO.** A zero lock count and an illegal VCO are both tried. A design that trusted the enable instead of the lock would switch early, or would hang on a PLL that can never lock.
- **Wait-state direction.** A frequency drop from 100 MHz to 40 MHz checks that the wait states fall only after the switch, since a reversed order would run fast flash reads too soon.
- **Silent crystal, stop wake and PLL-on-PLL.** A silent external oscillator while on an externally fed PLL, a stop wake during PLL operation and a PLL request while on the PLL probe the fallback paths and the drop rule. There, a wrong design would keep a dead clock, lose the sticky flag, or reprogram a running PLL.

// File: rtl/clkswitch_pkg.sv
package clkswitch_pkg;

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_RSVD = 2'd3
  } clk_src_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_EXT,
    ST_WAIT_LOCK,
    ST_ORDER,
    ST_SWITCH,
    ST_WS_DOWN
  } seq_state_e;

  // True when the given source needs the external oscillator running.
  function automatic logic needs_ext(clk_src_e s, logic pll_ref_ext);
    return (s == SRC_EXT) || ((s == SRC_PLL) && pll_ref_ext);
  endfunction

endpackage

// File: rtl/clksw_cfg_calc.sv
module clksw_cfg_calc
  import clkswitch_pkg::*;
#(
  parameter int INT_MHZ     = 16,
  parameter int EXT_MHZ     = 8,
  parameter int M_W         = 6,
  parameter int N_W         = 9,
  parameter int WS_W        = 4,
  parameter int WS_STEP_MHZ = 30,
  parameter int VCO_MIN_MHZ = 100,
  parameter int VCO_MAX_MHZ = 432
) (
  input  clk_src_e        src,
  input  logic            pll_ref_ext,
  input  logic [M_W-1:0]  m_div,
  input  logic [N_W-1:0]  n_mul,
  input  logic [1:0]      p_code,
  output logic [WS_W-1:0] ws_need,
  output logic            vco_legal
);
  localparam int FW     = 24;
  localparam int WS_MAX = (1 << WS_W) - 1;

  logic [FW-1:0] ref_mhz, prod, vco, sys_mhz, freq, quo;

  always_comb begin
    ref_mhz   = pll_ref_ext ? FW'(EXT_MHZ) : FW'(INT_MHZ);
    prod      = ref_mhz * FW'(n_mul);
    vco       = (m_div == '0) ? '0 : prod / FW'(m_div);
    vco_legal = (m_div != '0) && (vco >= FW'(VCO_MIN_MHZ)) && (vco <= FW'(VCO_MAX_MHZ));
    sys_mhz   = vco / (FW'(p_code) * FW'(2) + FW'(2));
    case (src)
      SRC_INT: freq = FW'(INT_MHZ);
      SRC_EXT: freq = FW'(EXT_MHZ);
      SRC_PLL: freq = sys_mhz;
      default: freq = '0;
    endcase
    quo     = (freq == '0) ? '0 : (freq - FW'(1)) / FW'(WS_STEP_MHZ);
    ws_need = (quo > FW'(WS_MAX)) ? WS_W'(WS_MAX) : quo[WS_W-1:0];
  end
endmodule

// File: rtl/clksw_lock_timer.sv
module clksw_lock_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_on,
  input  logic             vco_legal,
  input  logic [CNT_W-1:0] lock_cycles,
  output logic             locked
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!pll_on)              cnt_q <= '0;
    else if (cnt_q != lock_cycles) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign locked = pll_on && vco_legal && (cnt_q == lock_cycles);
endmodule

// File: rtl/clksw_osc_monitor.sv
module clksw_osc_monitor #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic watch,
  input  logic ext_clk,
  output logic trip
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] gap_q;
  logic          seen_edge;

  assign seen_edge = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      gap_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], ext_clk};
      if (!watch || seen_edge)          gap_q <= '0;
      else if (gap_q != CW'(WINDOW))    gap_q <= gap_q + CW'(1);
    end
  end

  assign trip = watch && (gap_q == CW'(WINDOW));
endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
  import clkswitch_pkg::*;
#(
  parameter int INT_MHZ     = 16,
  parameter int EXT_MHZ     = 8,
  parameter int M_W         = 6,
  parameter int N_W         = 9,
  parameter int WS_W        = 4,
  parameter int WS_STEP_MHZ = 30,
  parameter int VCO_MIN_MHZ = 100,
  parameter int VCO_MAX_MHZ = 432,
  parameter int LOCK_W      = 16,
  parameter int WAIT_LIMIT  = 4096,
  parameter int CSS_WINDOW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_src,
  input  logic              req_pll_ext,
  input  logic [M_W-1:0]    req_m,
  input  logic [N_W-1:0]    req_n,
  input  logic [1:0]        req_p,
  input  logic [LOCK_W-1:0] lock_cycles,
  input  logic              ext_rdy,
  input  logic              ext_clk,
  input  logic              stop_wake,
  output logic              ext_en,
  output logic              pll_en,
  output logic [WS_W-1:0]   flash_ws,
  output logic [1:0]        clk_sel,
  output logic              css_fail
);
  localparam int TMR_W = $clog2(WAIT_LIMIT);

  seq_state_e       st_q;
  clk_src_e         sel_q, tgt_src_q, req_src_e;
  logic             act_ref_ext_q, tgt_ref_ext_q, pll_cfg_ext_q, pll_vok_q;
  logic [WS_W-1:0]  ws_q, tgt_ws_q, req_ws;
  logic [TMR_W-1:0] tmr_q;
  logic             ext_en_q, pll_en_q, css_q;
  logic             req_vok, pll_locked, css_trip, force_int;
  logic             accept, drop, need_ext, tmr_done, keep_ext, keep_pll, req_ref_ext;

  assign req_src_e   = clk_src_e'(req_src);
  assign req_ref_ext = (req_src_e == SRC_PLL) && req_pll_ext;

  clksw_cfg_calc #(
    .INT_MHZ(INT_MHZ), .EXT_MHZ(EXT_MHZ), .M_W(M_W), .N_W(N_W), .WS_W(WS_W),
    .WS_STEP_MHZ(WS_STEP_MHZ), .VCO_MIN_MHZ(VCO_MIN_MHZ), .VCO_MAX_MHZ(VCO_MAX_MHZ)
  ) u_calc (
    .src(req_src_e), .pll_ref_ext(req_pll_ext), .m_div(req_m), .n_mul(req_n),
    .p_code(req_p), .ws_need(req_ws), .vco_legal(req_vok)
  );

  clksw_lock_timer #(.CNT_W(LOCK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .pll_on(pll_en_q), .vco_legal(pll_vok_q),
    .lock_cycles(lock_cycles), .locked(pll_locked)
  );

  clksw_osc_monitor #(.WINDOW(CSS_WINDOW)) u_mon (
    .clk(clk), .rst_n(rst_n), .watch(needs_ext(sel_q, act_ref_ext_q)),
    .ext_clk(ext_clk), .trip(css_trip)
  );

  assign force_int = css_trip || stop_wake;
  assign req_ready = (st_q == ST_IDLE) && !force_int;
  assign accept    = req_valid && req_ready;
  assign drop      = (req_src_e == SRC_RSVD) || ((req_src_e == SRC_PLL) && (sel_q == SRC_PLL));
  assign need_ext  = needs_ext(req_src_e, req_ref_ext);
  assign tmr_done  = (tmr_q == TMR_W'(WAIT_LIMIT - 1));
  assign keep_ext  = needs_ext(sel_q, act_ref_ext_q);
  assign keep_pll  = (sel_q == SRC_PLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      sel_q         <= SRC_INT;
      tgt_src_q     <= SRC_INT;
      act_ref_ext_q <= 1'b0;
      tgt_ref_ext_q <= 1'b0;
      pll_cfg_ext_q <= 1'b0;
      pll_vok_q     <= 1'b0;
      ws_q          <= '0;
      tgt_ws_q      <= '0;
      tmr_q         <= '0;
      ext_en_q      <= 1'b0;
      pll_en_q      <= 1'b0;
      css_q         <= 1'b0;
    end else if (force_int) begin
      sel_q         <= SRC_INT;
      act_ref_ext_q <= 1'b0;
      ext_en_q      <= 1'b0;
      pll_en_q      <= 1'b0;
      st_q          <= ST_IDLE;
      tmr_q         <= '0;
      if (css_trip) css_q <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept && !drop) begin
            tgt_src_q     <= req_src_e;
            tgt_ref_ext_q <= req_ref_ext;
            tgt_ws_q      <= req_ws;
            tmr_q         <= '0;
            if (req_src_e == SRC_PLL) begin
              pll_cfg_ext_q <= req_pll_ext;
              pll_vok_q     <= req_vok;
            end
            if (need_ext) begin
              ext_en_q <= 1'b1;
              st_q     <= ST_WAIT_EXT;
            end else if (req_src_e == SRC_PLL) begin
              pll_en_q <= 1'b1;
              st_q     <= ST_WAIT_LOCK;
            end else begin
              st_q <= ST_ORDER;
            end
          end
        end
        ST_WAIT_EXT: begin
          if (ext_rdy) begin
            if (tgt_src_q == SRC_PLL) begin
              pll_en_q <= 1'b1;
              st_q     <= ST_WAIT_LOCK;
            end else begin
              st_q <= ST_ORDER;
            end
          end else if (tmr_done) begin
            ext_en_q <= keep_ext;
            pll_en_q <= keep_pll;
            st_q     <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        ST_WAIT_LOCK: begin
          if (pll_locked) begin
            st_q <= ST_ORDER;
          end else if (tmr_done) begin
            ext_en_q <= keep_ext;
            pll_en_q <= keep_pll;
            st_q     <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        ST_ORDER: begin
          if (tgt_ws_q > ws_q) ws_q <= tgt_ws_q;
          st_q <= ST_SWITCH;
        end
        ST_SWITCH: begin
          sel_q         <= tgt_src_q;
          act_ref_ext_q <= tgt_ref_ext_q;
          ext_en_q      <= needs_ext(tgt_src_q, tgt_ref_ext_q);
          pll_en_q      <= (tgt_src_q == SRC_PLL);
          st_q          <= (tgt_ws_q < ws_q) ? ST_WS_DOWN : ST_IDLE;
        end
        ST_WS_DOWN: begin
          ws_q <= tgt_ws_q;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ext_en   = ext_en_q;
  assign pll_en   = pll_en_q;
  assign flash_ws = ws_q;
  assign clk_sel  = sel_q;
  assign css_fail = css_q;
endmodule

// File: rtl/clk_switch_ctrl_chk.sv
module clk_switch_ctrl_chk #(
  parameter int WS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      clk_sel,
  input logic [WS_W-1:0] flash_ws,
  input logic            ext_en,
  input logic            pll_en,
  input logic            ext_rdy,
  input logic            stop_wake,
  input logic            css_fail,
  input logic            pll_locked,
  input logic            pll_ref_ext
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (clk_sel == 2'd0 && flash_ws == '0 && !css_fail && !pll_en && !ext_en));

  assert_pll_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd2 && $past(clk_sel) != 2'd2) |-> $past(pll_locked));

  assert_ext_ready_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pll_en) && pll_ref_ext) |-> $past(ext_rdy));

  assert_ws_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_ws != $past(flash_ws)) |-> (clk_sel == $past(clk_sel)));

  assert_wake_internal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_wake) |-> (clk_sel == 2'd0 && !pll_en && !ext_en));

  assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(css_fail) |-> css_fail);

  assert_fail_fallback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(css_fail) |-> (clk_sel == 2'd0 && !pll_en && !ext_en));
endmodule

bind clk_switch_ctrl clk_switch_ctrl_chk #(.WS_W(WS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .flash_ws(flash_ws),
  .ext_en(ext_en), .pll_en(pll_en), .ext_rdy(ext_rdy), .stop_wake(stop_wake),
  .css_fail(css_fail), .pll_locked(pll_locked), .pll_ref_ext(pll_cfg_ext_q)
);

// File: tb/test_clk_switch_ctrl.sv
`timescale 1ns/1ps
module test_clk_switch_ctrl;
  localparam int WAIT_LIMIT = 4096;
  localparam int WINDOW     = 16;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_pll_ext = 0, ext_rdy = 1, ext_clk = 0, stop_wake = 0;
  logic [1:0]  req_src = 0, req_p = 0;
  logic [5:0]  req_m = 0;
  logic [8:0]  req_n = 0;
  logic [15:0] lock_cycles = 16'd40;
  logic        req_ready, ext_en, pll_en, css_fail;
  logic [3:0]  flash_ws;
  logic [1:0]  clk_sel;
  bit          ext_alive = 1;
  int          checks = 0, errors = 0;

  clk_switch_ctrl i_clk_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_pll_ext(req_pll_ext), .req_m(req_m), .req_n(req_n),
    .req_p(req_p), .lock_cycles(lock_cycles), .ext_rdy(ext_rdy), .ext_clk(ext_clk),
    .stop_wake(stop_wake), .ext_en(ext_en), .pll_en(pll_en), .flash_ws(flash_ws),
    .clk_sel(clk_sel), .css_fail(css_fail)
  );

  always #2.5 clk = ~clk;

  always begin
    repeat (2) @(negedge clk);
    if (ext_alive) ext_clk = ~ext_clk;
  end

  // Behavioural reference model
  int m_st, m_sel, m_apext, m_ext_en, m_pll_en, m_ws, m_css, m_tmr, m_lk, m_cc;
  int m_tsrc, m_tpext, m_tws, m_vok, m_pext_cfg, m_s1, m_s2, m_s3;

  function automatic int ws_of(int src, int pext, int m, int n, int p);
    int f, vco;
    f = 0;
    if (src == 0) f = 16;
    else if (src == 1) f = 8;
    else if (src == 2 && m != 0) begin
      vco = (pext ? 8 : 16) * n / m;
      f = vco / (2 * (p + 1));
    end
    if (f == 0) return 0;
    return ((f - 1) / 30 > 15) ? 15 : (f - 1) / 30;
  endfunction

  function automatic int vok_of(int pext, int m, int n);
    int vco;
    if (m == 0) return 0;
    vco = (pext ? 8 : 16) * n / m;
    return (vco >= 100 && vco <= 432) ? 1 : 0;
  endfunction

  function automatic int uses_ext(int s, int pe);
    return (s == 1 || (s == 2 && pe != 0)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int mon, trip, locked, n_cc, n_lk, rpe;
    if (!rst_n) begin
      m_st = 0; m_sel = 0; m_apext = 0; m_ext_en = 0; m_pll_en = 0; m_ws = 0; m_css = 0;
      m_tmr = 0; m_lk = 0; m_cc = 0; m_tsrc = 0; m_tpext = 0; m_tws = 0; m_vok = 0;
      m_pext_cfg = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      mon    = uses_ext(m_sel, m_apext);
      trip   = (mon != 0 && m_cc == WINDOW) ? 1 : 0;
      locked = (m_pll_en != 0 && m_vok != 0 && m_lk == int'(lock_cycles)) ? 1 : 0;
      n_cc   = (mon == 0 || m_s3 != m_s2) ? 0 : ((m_cc != WINDOW) ? m_cc + 1 : m_cc);
      n_lk   = (m_pll_en == 0) ? 0 : ((m_lk != int'(lock_cycles)) ? m_lk + 1 : m_lk);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ext_clk);
      m_cc = n_cc; m_lk = n_lk;
      if (trip != 0 || stop_wake) begin
        m_sel = 0; m_apext = 0; m_ext_en = 0; m_pll_en = 0; m_st = 0; m_tmr = 0;
        if (trip != 0) m_css = 1;
      end else begin
        case (m_st)
          0: if (req_valid && !(req_src == 3 || (req_src == 2 && m_sel == 2))) begin
               rpe = (req_src == 2 && req_pll_ext) ? 1 : 0;
               m_tsrc = int'(req_src); m_tpext = rpe; m_tmr = 0;
               m_tws = ws_of(int'(req_src), int'(req_pll_ext), int'(req_m), int'(req_n), int'(req_p));
               if (req_src == 2) begin
                 m_pext_cfg = int'(req_pll_ext);
                 m_vok = vok_of(int'(req_pll_ext), int'(req_m), int'(req_n));
               end
               if (uses_ext(int'(req_src), rpe) != 0) begin m_ext_en = 1; m_st = 1; end
               else if (req_src == 2) begin m_pll_en = 1; m_st = 2; end
               else m_st = 3;
             end
          1: if (ext_rdy) begin
               if (m_tsrc == 2) begin m_pll_en = 1; m_st = 2; end else m_st = 3;
             end else if (m_tmr == WAIT_LIMIT - 1) begin
               m_ext_en = uses_ext(m_sel, m_apext); m_pll_en = (m_sel == 2) ? 1 : 0; m_st = 0;
             end else m_tmr++;
          2: if (locked != 0) m_st = 3;
             else if (m_tmr == WAIT_LIMIT - 1) begin
               m_ext_en = uses_ext(m_sel, m_apext); m_pll_en = (m_sel == 2) ? 1 : 0; m_st = 0;
             end else m_tmr++;
          3: begin if (m_tws > m_ws) m_ws = m_tws; m_st = 4; end
          4: begin
               m_sel = m_tsrc; m_apext = m_tpext;
               m_ext_en = uses_ext(m_tsrc, m_tpext); m_pll_en = (m_tsrc == 2) ? 1 : 0;
               m_st = (m_tws < m_ws) ? 5 : 0;
             end
          default: begin m_ws = m_tws; m_st = 0; end
        endcase
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    int mrdy;
    if (rst_n) begin
      mrdy = (m_st == 0 && !stop_wake &&
              !(uses_ext(m_sel, m_apext) != 0 && m_cc == WINDOW)) ? 1 : 0;
      cmp("R2 req_ready", int'(req_ready), mrdy);
      cmp("R8 clk_sel", int'(clk_sel), m_sel);
      cmp("R7 flash_ws", int'(flash_ws), m_ws);
      cmp("R5 pll_en", int'(pll_en), m_pll_en);
      cmp("R12 ext_en", int'(ext_en), m_ext_en);
      cmp("R11 css_fail", int'(css_fail), m_css);
    end
  end

  task automatic send(int src, int pext, int m, int n, int p);
    @(posedge clk); #1;
    req_valid = 1; req_src = 2'(src); req_pll_ext = 1'(pext);
    req_m = 6'(m); req_n = 9'(n); req_p = 2'(p);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (req_ready && m_st == 0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset clk_sel", int'(clk_sel), 0);
    cmp("R1 reset ready", int'(req_ready), 1);
    cmp("R1 reset ws", int'(flash_ws), 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    cmp("R1 released clk_sel", int'(clk_sel), 0);
    cmp("R1 released enables", int'({ext_en, pll_en, css_fail}), 0);

    send(1, 0, 0, 0, 0); wait_idle();
    cmp("R8 external active", int'(clk_sel), 1);
    cmp("R3 external ws", int'(flash_ws), 0);

    // external-fed PLL 168 MHz, with a second request queued behind it
    send(2, 1, 8, 336, 0);
    send(0, 0, 0, 0, 0);
    @(negedge clk);
    cmp("R2 queued request waited for PLL", int'(clk_sel), 2);
    cmp("R3 ws for 168 MHz", int'(flash_ws), 5);
    wait_idle();
    cmp("R12 back on internal", int'({clk_sel, ext_en, pll_en}), 0);
    cmp("R7 ws lowered", int'(flash_ws), 0);

    send(2, 0, 16, 200, 0); wait_idle();
    cmp("R3 ws for 100 MHz", int'(flash_ws), 3);
    cmp("R12 internal-fed PLL keeps ext off", int'(ext_en), 0);

    send(2, 0, 8, 100, 0); wait_idle();
    cmp("R9 PLL request on PLL dropped", int'(flash_ws), 3);
    send(3, 0, 0, 0, 0); wait_idle();
    cmp("R2 reserved code dropped", int'(clk_sel), 2);

    @(posedge clk); #1 stop_wake = 1;
    @(posedge clk); #1 stop_wake = 0;
    @(negedge clk);
    cmp("R10 wake to internal", int'(clk_sel), 0);
    cmp("R10 wake keeps ws", int'(flash_ws), 3);

    send(2, 0, 16, 50, 0); wait_idle();
    cmp("R4 illegal VCO stays internal", int'(clk_sel), 0);
    cmp("R4 PLL off after abandon", int'(pll_en), 0);

    lock_cycles = 16'd0;
    send(2, 0, 4, 40, 1); wait_idle();
    cmp("R5 zero lock count", int'(clk_sel), 2);
    cmp("R7 ws 40 MHz", int'(flash_ws), 1);
    lock_cycles = 16'd40;

    ext_rdy = 0;
    send(1, 0, 0, 0, 0); wait_idle();
    cmp("R6 no ext ready keeps PLL", int'(clk_sel), 2);
    cmp("R6 ext turned off", int'(ext_en), 0);
    ext_rdy = 1;

    send(0, 0, 0, 0, 0); wait_idle();
    send(2, 1, 8, 216, 1); wait_idle();
    cmp("R3 ws for 54 MHz", int'(flash_ws), 1);
    ext_alive = 0;
    repeat (40) @(negedge clk);
    cmp("R11 fallback", int'({clk_sel, ext_en, pll_en}), 0);
    cmp("R11 flag set", int'(css_fail), 1);
    ext_alive = 1;
    send(1, 0, 0, 0, 0); wait_idle();
    cmp("R11 flag sticky", int'(css_fail), 1);
    cmp("R8 external again", int'(clk_sel), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule